// File: doc/BRIEF.md
# I2C Command Receiver for a 12-bit DAC

This block is the serial front end of a 12-bit digital-to-analog converter. It acts as an I2C target with separate SCL/SDA inputs and an open-drain pull-down enable. It decodes write frames into a live DAC register, which holds a 12-bit code and two power-down select bits. One command also copies the value into a nonvolatile shadow. A write to that shadow is modelled as a fixed busy window, counted in system clocks. A read frame returns a status byte with the ready flag, followed by the live code.

A write takes effect only when its frame is complete. There are two frame forms. In the short form, the command bits and the upper code nibble share one byte. In the long form, a command byte is followed by two data bytes. If the host keeps sending after a complete group without a STOP, each further group is applied in the same way. Truncated groups are dropped.

Top module: `i2c_dac_cmd`

## Requirements
- R1: After reset the live code, the power-down bits and the shadow copy are all zero, the ready flag is 1, and SDA is released.
- R2: The target ACKs only the 7-bit address 1100, then the two build-time bits, then the level of the addrSel pin. Any other address is NACKed and changes nothing.
- R3: When bits 7:6 of the first data byte are 00, the frame is the short form: bits 5:4 are PD1 PD0, bits 3:0 are D11–D8, and the next byte is D7–D0. The live register updates after that byte is ACKed, and the shadow is untouched.
- R4: Command 010 in bits 7:5 of the first data byte is the long form: PD1 PD0 sit in bits 2:1, byte 2 of the group is D11–D4, and bits 7:4 of byte 3 are D3–D0. Bits 4:3 and 0 of byte 1 and bits 3:0 of byte 3 are ignored. The update follows the ACK of byte 3, and the shadow is untouched.
- R5: A group whose command bits 7:5 are 100, 101, 110 or 111 is ACKed but changes no state.
- R6: A STOP or repeated START before a group is complete discards that group, and the next data byte is read as a command byte.
- R7: Without a STOP, each further complete group (two bytes in the short form, three in the long form) is decoded and applied as a new command.
- R8: Command 011 loads the live register and the shadow together. The ready flag then stays 0 for exactly BUSY_CYCLES clocks.
- R9: A 011 group that completes while the ready flag is 0 is ignored completely, and neither register changes.
- R10: A read returns, in a repeating cycle of three bytes: {ready, 00000, PD1, PD0}, then D11–D4, then {D3–D0, 0000}. A host NACK ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| addrSel | input | 1 | Least significant address bit |
| sdaOe | output | 1 | 1 pulls SDA low |
| dacCode | output | 12 | Live DAC code |
| pdSel | output | 2 | Live power-down select |
| nvCode | output | 12 | Shadow copy of the code |
| nvPd | output | 2 | Shadow copy of the power-down bits |
| nvReady | output | 1 | 0 while the shadow write is busy |

## Verification
A register update follows the SCL falling edge that ends the ACK of the group's last byte. It passes through the synchroniser and edge detector (SYNC_STAGES+1 clocks), the strobe register and the output register, so it lands about five clocks after that edge. The bench holds SCL low for eight clocks after every ACK before it samples, so each check after a byte, including those in the middle of a frame, reads settled values. The busy window is measured by a monitor that counts the clocks during which nvReady is 0 and compares the count with BUSY_CYCLES. Read bytes are sampled at the middle of SCL high, long after the target has changed SDA.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int CODE_W = 12;
  localparam int PD_W   = 2;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              commitDac;
    logic              writeBoth;
    logic [CODE_W-1:0] code;
    logic [PD_W-1:0]   pd;
  } dacStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK_ADDR, S_WRITE, S_ACK_WRITE, S_READ, S_READ_ACK
  } linkState_t;
endpackage

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter logic [1:0] ADDR_HI     = 2'b00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  logic              rdReady,
  input  logic [CODE_W-1:0] rdCode,
  input  logic [PD_W-1:0]   rdPd,
  output logic              sdaOe,
  output dacStrobe_t        strb
);
  localparam logic [3:0] DEV_ID = 4'b1100;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES:0] sclSync, sdaSync;
  logic sclNow, sclPrev, sdaNow, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-1:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow   = sclSync[SYNC_STAGES-1];
  assign sclPrev  = sclSync[SYNC_STAGES];
  assign sdaNow   = sdaSync[SYNC_STAGES-1];
  assign sdaPrev  = sdaSync[SYNC_STAGES];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  linkState_t        state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg, txShift, txNext;
  logic              readMode, masterAck;
  logic [1:0]        rdIdx, rdIdxNext;
  logic [1:0]        groupPos;
  logic [2:0]        cmdReg;
  logic [PD_W-1:0]   pdHold;
  logic [CODE_W-1:0] codeHold;
  logic              addrHit;

  assign addrHit   = shiftReg[7:1] == {DEV_ID, ADDR_HI, addrSel};
  assign rdIdxNext = (rdIdx == 2'd2) ? 2'd0 : rdIdx + 2'd1;

  always_comb begin
    case (rdIdx)
      2'd0:    txNext = {rdReady, 5'b0, rdPd};
      2'd1:    txNext = rdCode[CODE_W-1 -: BYTE_W];
      default: txNext = {rdCode[CODE_W-BYTE_W-1:0], {(2*BYTE_W-CODE_W){1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      txShift   <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      rdIdx     <= '0;
      groupPos  <= '0;
      cmdReg    <= '0;
      pdHold    <= '0;
      codeHold  <= '0;
      sdaOe     <= 1'b0;
      strb      <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        state    <= S_ADDR;
        bitCnt   <= '0;
        groupPos <= '0;
        rdIdx    <= '0;
        sdaOe    <= 1'b0;
      end else if (stopDet) begin
        state    <= S_IDLE;
        groupPos <= '0;
        sdaOe    <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WRITE: begin
            if (sclRise && bitCnt != FULL_BYTE) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL_BYTE) begin
              if (state == S_WRITE) begin
                sdaOe <= 1'b1;
                state <= S_ACK_WRITE;
              end else if (addrHit) begin
                sdaOe    <= 1'b1;
                readMode <= shiftReg[0];
                state    <= S_ACK_ADDR;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ACK_ADDR: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (readMode) begin
                txShift <= txNext;
                sdaOe   <= ~txNext[BYTE_W-1];
                rdIdx   <= rdIdxNext;
                state   <= S_READ;
              end else begin
                sdaOe <= 1'b0;
                state <= S_WRITE;
              end
            end
          end
          S_ACK_WRITE: begin
            if (sclFall) begin
              sdaOe  <= 1'b0;
              bitCnt <= '0;
              state  <= S_WRITE;
              case (groupPos)
                2'd0: begin
                  cmdReg   <= shiftReg[7:5];
                  groupPos <= 2'd1;
                  if (shiftReg[7:6] == 2'b00) begin
                    pdHold         <= shiftReg[5:4];
                    codeHold[11:8] <= shiftReg[3:0];
                  end else begin
                    pdHold <= shiftReg[2:1];
                  end
                end
                2'd1: begin
                  if (cmdReg[2:1] == 2'b00) begin
                    strb.commitDac <= 1'b1;
                    strb.code      <= {codeHold[11:8], shiftReg};
                    strb.pd        <= pdHold;
                    groupPos       <= 2'd0;
                  end else begin
                    codeHold[11:4] <= shiftReg;
                    groupPos       <= 2'd2;
                  end
                end
                default: begin
                  strb.commitDac <= (cmdReg == 3'b010);
                  strb.writeBoth <= (cmdReg == 3'b011);
                  strb.code      <= {codeHold[11:4], shiftReg[7:4]};
                  strb.pd        <= pdHold;
                  groupPos       <= 2'd0;
                end
              endcase
            end
          end
          S_READ: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaOe <= 1'b0;
                state <= S_READ_ACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaOe   <= ~txShift[BYTE_W-2];
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
          S_READ_ACK: begin
            if (sclRise) begin
              masterAck <= ~sdaNow;
            end else if (sclFall) begin
              if (masterAck) begin
                txShift <= txNext;
                sdaOe   <= ~txNext[BYTE_W-1];
                rdIdx   <= rdIdxNext;
                bitCnt  <= '0;
                state   <= S_READ;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_ADDR |-> !sdaOe);
  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_IDLE |-> !sdaOe);
  // R5
  reserved_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitDac || strb.writeBoth) |-> !cmdReg[2]);
  // R6
  frame_edge_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |=> !(strb.commitDac || strb.writeBoth));
endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
  import dac_cmd_pkg::*;
#(
  parameter int BUSY_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobe_t        strb,
  output logic [CODE_W-1:0] dacCode,
  output logic [PD_W-1:0]   pdSel,
  output logic [CODE_W-1:0] nvCode,
  output logic [PD_W-1:0]   nvPd,
  output logic              nvReady
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  logic [BUSY_W-1:0] busyCnt;
  logic busy, nvAccept;

  assign busy     = busyCnt != '0;
  assign nvAccept = strb.writeBoth && !busy;
  assign nvReady  = !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
      pdSel   <= '0;
      nvCode  <= '0;
      nvPd    <= '0;
      busyCnt <= '0;
    end else begin
      if (strb.commitDac || nvAccept) begin
        dacCode <= strb.code;
        pdSel   <= strb.pd;
      end
      if (nvAccept) begin
        nvCode  <= strb.code;
        nvPd    <= strb.pd;
        busyCnt <= BUSY_LOAD;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nvReady) |-> $past(strb.writeBoth));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeBoth && !nvReady) |=> ($stable(dacCode) && $stable(nvCode)));
  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeBoth |=> ($stable(nvCode) && $stable(nvPd)));
  // R4
  live_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commitDac || strb.writeBoth) |=> ($stable(dacCode) && $stable(pdSel)));
endmodule

// File: rtl/i2c_dac_cmd.sv
module i2c_dac_cmd
  import dac_cmd_pkg::*;
#(
  parameter logic [1:0] ADDR_HI     = 2'b00,
  parameter int         SYNC_STAGES = 2,
  parameter int         BUSY_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  output logic              sdaOe,
  output logic [CODE_W-1:0] dacCode,
  output logic [PD_W-1:0]   pdSel,
  output logic [CODE_W-1:0] nvCode,
  output logic [PD_W-1:0]   nvPd,
  output logic              nvReady
);
  dacStrobe_t strb;

  dac_cmd_ctrl #(.ADDR_HI(ADDR_HI), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdReady(nvReady), .rdCode(dacCode), .rdPd(pdSel), .sdaOe(sdaOe), .strb(strb)
  );

  dac_cmd_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .dacCode(dacCode), .pdSel(pdSel),
    .nvCode(nvCode), .nvPd(nvPd), .nvReady(nvReady)
  );
endmodule

// File: tb/test_i2c_dac_cmd.sv
module test_i2c_dac_cmd;
  localparam int BUSY = 5000;
  localparam int Q    = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic scl = 1'b1, mSda = 1'b1, addrSel = 1'b0;
  logic sdaOe, nvReady, sdaLine;
  logic [11:0] dacCode, nvCode;
  logic [1:0]  pdSel, nvPd;
  int vectors = 0, fails = 0;
  int runLen = 0, lastRun = 0;

  always #10 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  i2c_dac_cmd #(.ADDR_HI(2'b00), .SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) i_i2c_dac_cmd (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .dacCode(dacCode), .pdSel(pdSel), .nvCode(nvCode),
    .nvPd(nvPd), .nvReady(nvReady)
  );

  always @(negedge clk) begin
    if (rstN && !nvReady) runLen++;
    else if (runLen != 0) begin lastRun = runLen; runLen = 0; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart;
    mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); mSda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic i2cStop;
    mSda = 1'b0; tick(Q); scl = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
  endtask
  task automatic wrBit(input logic b);
    mSda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask
  task automatic rdBit(output logic b);
    mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sdaLine; tick(Q); scl = 1'b0; tick(Q);
  endtask
  task automatic wrByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wrBit(d[i]);
    rdBit(b);
    ack = ~b;
  endtask
  task automatic rdByte(input logic ackIt, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rdBit(d[i]);
    wrBit(~ackIt);
  endtask

  logic [7:0] addrW, addrR;
  logic a;

  task automatic fastFrame(input logic [1:0] pd, input logic [11:0] code);
    i2cStart; wrByte(addrW, a); wrByte({2'b00, pd, code[11:8]}, a); wrByte(code[7:0], a); i2cStop;
  endtask
  task automatic longFrame(input logic [2:0] cmd, input logic [1:0] pd,
                           input logic [11:0] code, input logic [3:0] junk);
    i2cStart; wrByte(addrW, a);
    wrByte({cmd, junk[1:0], pd, junk[2]}, a);
    wrByte(code[11:4], a); wrByte({code[3:0], junk}, a); i2cStop;
  endtask

  initial begin
    logic [11:0] code, expCode, expNv;
    logic [1:0]  pd, expPd;
    logic [7:0]  rb;
    tick(4); rstN = 1'b1; tick(4);
    // R1 reset state
    check("R1 code", dacCode, 0); check("R1 pd", pdSel, 0);
    check("R1 nv", {nvPd, nvCode}, 0); check("R1 ready", nvReady, 1); check("R1 sda", sdaOe, 0);

    // R2 address sweep over pin level and low address bits
    for (int p = 0; p < 2; p++) begin
      addrSel = p[0];
      for (int lo = 0; lo < 8; lo++) begin
        i2cStart; wrByte({4'b1100, lo[2:0], 1'b0}, a);
        if (a) begin wrByte(8'h0F, a); wrByte(8'hFF, a); end
        else begin wrByte(8'h0F, a); wrByte(8'hFF, a); end
        i2cStop;
        check("R2 ack", a, 32'(lo == p));
        check("R2 state", dacCode, (lo == p) ? 12'hFFF : 12'h000);
        if (lo == p) begin
          i2cStart; wrByte({4'b1100, lo[2:0], 1'b0}, a);
          wrByte(8'h00, a); wrByte(8'h00, a); i2cStop;
        end
      end
    end
    i2cStart; wrByte({7'b1010_000, 1'b0}, a); i2cStop;
    check("R2 foreign id", a, 0);
    addrSel = 1'b1;
    addrW = {7'b1100_001, 1'b0};
    addrR = {7'b1100_001, 1'b1};

    // R3 short form sweep
    for (int i = 0; i < 16; i++) begin
      code = 12'(i * 273); pd = 2'(i);
      fastFrame(pd, code);
      check("R3 code", dacCode, code); check("R3 pd", pdSel, pd); check("R3 nv", nvCode, 0);
    end

    // R4 long form 010 with junk in ignored bits
    for (int i = 0; i < 8; i++) begin
      code = 12'hFFF - 12'(i * 517); pd = 2'(3 - (i % 4));
      longFrame(3'b010, pd, code, 4'(i * 5 + 3));
      check("R4 code", dacCode, code); check("R4 pd", pdSel, pd); check("R4 nv", nvCode, 0);
    end
    expCode = dacCode; expPd = pdSel;

    // R5 reserved commands
    for (int c = 4; c < 8; c++) begin
      longFrame(3'(c), 2'b11, 12'h5A5, 4'h0);
      check("R5 code", dacCode, expCode); check("R5 pd", pdSel, expPd);
      check("R5 nv", {nvPd, nvCode}, 0); check("R5 ready", nvReady, 1);
    end

    // R6 truncated groups
    i2cStart; wrByte(addrW, a); wrByte({3'b010, 2'b00, 2'b10, 1'b0}, a); wrByte(8'h12, a); i2cStop;
    check("R6 long partial", dacCode, expCode);
    i2cStart; wrByte(addrW, a); wrByte(8'h2C, a); i2cStop;
    check("R6 short partial", dacCode, expCode);
    i2cStart; wrByte(addrW, a); wrByte({3'b010, 4'b0010}, a); wrByte(8'hAB, a);
    i2cStart; wrByte(addrW, a); wrByte(8'h1C, a); wrByte(8'h3D, a); i2cStop;
    check("R6 restart code", dacCode, 12'hC3D); check("R6 restart pd", pdSel, 2'b01);

    // R7 continued groups in one frame
    i2cStart; wrByte(addrW, a);
    wrByte({3'b010, 2'b00, 2'b11, 1'b0}, a); wrByte(8'h9E, a); wrByte(8'h70, a);
    check("R7 group1", {pdSel, dacCode}, {2'b11, 12'h9E7});
    wrByte({3'b010, 2'b00, 2'b01, 1'b0}, a); wrByte(8'h12, a); wrByte(8'h3F, a);
    check("R7 group2", {pdSel, dacCode}, {2'b01, 12'h123});
    wrByte(8'h24, a); wrByte(8'h56, a);
    check("R7 short group", {pdSel, dacCode}, {2'b10, 12'h456});
    wrByte(8'h0A, a);
    check("R7 half group", dacCode, 12'h456);
    wrByte(8'hBC, a); i2cStop;
    check("R7 short group2", {pdSel, dacCode}, {2'b00, 12'hABC});

    // R8 write to both
    longFrame(3'b011, 2'b10, 12'h6D2, 4'hF);
    check("R8 code", dacCode, 12'h6D2); check("R8 nv", {nvPd, nvCode}, {2'b10, 12'h6D2});
    check("R8 busy", nvReady, 0);
    // R10 status during busy
    i2cStart; wrByte(addrR, a); rdByte(1'b0, rb); i2cStop;
    check("R10 busy status", rb, 8'h02);
    // R9 second 011 while busy
    longFrame(3'b011, 2'b01, 12'h111, 4'h0);
    check("R9 code", dacCode, 12'h6D2); check("R9 nv", nvCode, 12'h6D2); check("R9 pd", nvPd, 2'b10);
    for (int k = 0; k < 3 * BUSY && !nvReady; k++) tick(1);
    tick(2);
    check("R8 busy length", lastRun, BUSY);
    check("R8 ready back", nvReady, 1);
    expNv = nvCode;
    // R10 read cycle with wrap
    i2cStart; wrByte(addrR, a);
    check("R10 addr ack", a, 1);
    rdByte(1'b1, rb); check("R10 status", rb, 8'h82);
    rdByte(1'b1, rb); check("R10 hi", rb, 8'h6D);
    rdByte(1'b1, rb); check("R10 lo", rb, 8'h20);
    rdByte(1'b0, rb); check("R10 wrap", rb, 8'h82);
    i2cStop;
    check("R10 released", sdaOe, 0);
    fastFrame(2'b00, 12'h3A7);
    check("R3 after nv", {dacCode, nvCode}, {12'h3A7, expNv});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule